// File: doc/BRIEF.md
# 1-Wire Slave Bit-Timing Front End

This block sits between an open-drain 1-Wire bus line and the byte-level logic of a slave device. It brings the line into the clock domain, finds its falling and rising edges, and times every low pulse in whole microseconds. A divider turns the system clock into the microsecond tick. When the line returns high, the low time decides what the pulse was. A long pulse is a bus reset, and the block answers it with a presence pulse. A shorter pulse is a time slot, and it yields one received bit.

Toward the upper layer the block gives a single-cycle reset strobe and a stream of received bits. The upper layer answers read slots through a level input that asks for a zero. That input is sampled at the master's falling edge. When it is set, the block holds the line low for a fixed time. The bit stream carries a valid strobe and no ready. The bus sets the pace, so back-pressure is not possible: the consumer must accept each bit in the cycle its valid is high. The block only ever enables a pull-down. It never drives the line high. Edges that the block causes itself are hidden from the slot logic.

Top module: `ow_slot_front`

## Requirements
- R1: During and right after reset, `drive_low_o`, `rst_o` and `bit_valid_o` are all 0.
- R2: A low pulse of `RESET_US` (256) microseconds or longer gives exactly one single-cycle `rst_o` pulse after the line rises. It gives no `bit_valid_o`. A pulse one microsecond shorter is not a reset.
- R3: `drive_low_o` rises in the same cycle as `rst_o`. It stays high for exactly `PRESENCE_US*CLK_PER_US-1` cycles (120 µs of ticks).
- R4: A low pulse shorter than `ONE_MAX_US` (16) microseconds gives one `bit_valid_o` cycle with `bit_o` = 1.
- R5: A low pulse from `ONE_MAX_US` microseconds up to `RESET_US-1` microseconds gives one `bit_valid_o` cycle with `bit_o` = 0.
- R6: If `tx_zero_i` is 1 at a master falling edge, `drive_low_o` is held high for exactly `HOLD0_US*CLK_PER_US-1` cycles (15 µs). If it is 0, the line is not driven.
- R7: Edges caused by the block's own drive produce neither `rst_o` nor `bit_valid_o`. This covers the end of a presence pulse and the end of a held zero.
- R8: `rst_o` and `bit_valid_o` are single-cycle strobes and are never high together.
- R9: `drive_low_o` rises only in answer to a reset or to a falling edge seen with `tx_zero_i` set. Holding `tx_zero_i` high on an idle line has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_i | input | 1 | Sensed level of the bus line (asynchronous) |
| drive_low_o | output | 1 | Enable for the pull-down; 1 pulls the line low |
| tx_zero_i | input | 1 | Upper layer asks to answer the next slot with a zero |
| rst_o | output | 1 | One-cycle strobe: a bus reset was seen |
| bit_valid_o | output | 1 | One-cycle valid for a received bit (no ready) |
| bit_o | output | 1 | Received bit value, qualified by `bit_valid_o` |

## Verification
The master model drives low pulses of 1, 15, 16, 60, 255 and 256 microseconds. The pairs 15/16 and 255/256 sit on each side of a classification boundary, so an off-by-one in the tick phase or in a compare shows up as a wrong bit or a missing reset. Read slots run both with and without the zero request. The exact width of the pull-down is counted in cycles, which separates a correct hold from one a tick too long or too short. A request held high on an idle line, and the rising edges that the block causes itself, show that only a master falling edge or a reset can start a drive.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    DRV_IDLE = 2'd0,
    DRV_PRES = 2'd1,
    DRV_HOLD = 2'd2
  } drv_state_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;
endpackage

// File: rtl/ow_edge_sync.sv
module ow_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output ow_pkg::edge_evt_t evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    evt_o.rise = sync_q[SYNC_STAGES-1] & ~prev_q;
    evt_o.fall = ~sync_q[SYNC_STAGES-1] & prev_q;
  end
endmodule

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int CLK_PER_US = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);
  localparam logic [DIV_W-1:0] DIV_RST  = DIV_W'((CLK_PER_US > 1) ? 1 : 0);

  logic [DIV_W-1:0] div_q;

  assign tick_o = (div_q == DIV_LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (restart_i) begin
      div_q <= DIV_RST;
    end else if (tick_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/ow_low_timer.sv
module ow_low_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] us_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign us_o = cnt_q;
endmodule

// File: rtl/ow_drive_ctl.sv
module ow_drive_ctl #(
  parameter int PRESENCE_US = 120,
  parameter int HOLD0_US    = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_pres_i,
  input  logic start_hold_i,
  output logic drive_o
);
  import ow_pkg::*;

  localparam int LONGEST = (PRESENCE_US > HOLD0_US) ? PRESENCE_US : HOLD0_US;
  localparam int DW      = $clog2(LONGEST + 1);
  localparam logic [DW-1:0] PRES_LOAD = DW'(PRESENCE_US);
  localparam logic [DW-1:0] HOLD_LOAD = DW'(HOLD0_US);

  drv_state_e    state_q;
  logic [DW-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= DRV_IDLE;
      left_q  <= '0;
    end else if (start_pres_i) begin
      state_q <= DRV_PRES;
      left_q  <= PRES_LOAD;
    end else if (start_hold_i && (state_q == DRV_IDLE)) begin
      state_q <= DRV_HOLD;
      left_q  <= HOLD_LOAD;
    end else if ((state_q != DRV_IDLE) && tick_i) begin
      if (left_q <= DW'(1)) begin
        state_q <= DRV_IDLE;
        left_q  <= '0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign drive_o = (state_q != DRV_IDLE);
endmodule

// File: rtl/ow_slot_front.sv
module ow_slot_front #(
  parameter int CLK_PER_US  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_US    = 256,
  parameter int ONE_MAX_US  = 16,
  parameter int PRESENCE_US = 120,
  parameter int HOLD0_US    = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic drive_low_o,
  input  logic tx_zero_i,
  output logic rst_o,
  output logic bit_valid_o,
  output logic bit_o
);
  import ow_pkg::*;

  localparam int CNT_W = $clog2(RESET_US + 1) + 1;
  localparam int GUARD = SYNC_STAGES + 2;
  localparam logic [CNT_W-1:0] RESET_LIM = CNT_W'(RESET_US);
  localparam logic [CNT_W-1:0] ONE_LIM   = CNT_W'(ONE_MAX_US);

  edge_evt_t        evt;
  logic             tick;
  logic [CNT_W-1:0] low_us;
  logic             drive;
  logic [GUARD-1:0] drv_hist_q;
  logic             self_mask;
  logic             ok_rise, ok_fall, edge_any, is_reset;
  logic             rst_q, bitv_q, bit_q;

  ow_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(bus_i),
    .evt_o (evt)
  );

  // Edges within a short window of our own pull-down belong to us.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) drv_hist_q <= '0;
    else         drv_hist_q <= {drv_hist_q[GUARD-2:0], drive};
  end

  assign self_mask = drive | (|drv_hist_q);
  assign ok_rise   = evt.rise & ~self_mask;
  assign ok_fall   = evt.fall & ~self_mask;
  assign edge_any  = ok_rise | ok_fall;

  ow_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(edge_any),
    .tick_o   (tick)
  );

  ow_low_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(edge_any),
    .tick_i   (tick),
    .us_o     (low_us)
  );

  assign is_reset = (low_us >= RESET_LIM);

  ow_drive_ctl #(
    .PRESENCE_US(PRESENCE_US),
    .HOLD0_US   (HOLD0_US)
  ) u_drive (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .start_pres_i(ok_rise & is_reset),
    .start_hold_i(ok_fall & tx_zero_i),
    .drive_o     (drive)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      bitv_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      rst_q  <= ok_rise & is_reset;
      bitv_q <= ok_rise & ~is_reset;
      if (ok_rise && !is_reset) bit_q <= (low_us < ONE_LIM);
    end
  end

  assign drive_low_o = drive;
  assign rst_o       = rst_q;
  assign bit_valid_o = bitv_q;
  assign bit_o       = bit_q;
endmodule

// File: rtl/ow_slot_front_chk.sv
module ow_slot_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic drive_low_o,
  input logic tx_zero_i,
  input logic rst_o,
  input logic bit_valid_o
);
  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_o && bit_valid_o));

  assert_bit_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  assert_rst_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |=> !rst_o);

  assert_presence_with_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> drive_low_o);

  assert_drive_has_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_low_o) |-> (rst_o || $past(tx_zero_i)));

  assert_no_bit_while_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_low_o |-> !bit_valid_o);
endmodule

bind ow_slot_front ow_slot_front_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .drive_low_o(drive_low_o),
  .tx_zero_i  (tx_zero_i),
  .rst_o      (rst_o),
  .bit_valid_o(bit_valid_o)
);

// File: tb/test_ow_slot_front.sv
module test_ow_slot_front;
  localparam int CPU  = 100;
  localparam int PRES = 120;
  localparam int HOLD = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic tx_zero = 1'b0;
  logic drive_low, rst_s, bitv, bitval;
  logic bus;

  int n_tests = 0;
  int n_fail  = 0;
  int n_rst   = 0;
  int n_bit   = 0;
  logic last_bit = 1'b0;

  always #5 clk = ~clk;

  assign bus = ~(m_low | drive_low);

  ow_slot_front #(
    .CLK_PER_US (CPU),
    .PRESENCE_US(PRES),
    .HOLD0_US   (HOLD)
  ) i_ow_slot_front (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_i      (bus),
    .drive_low_o(drive_low),
    .tx_zero_i  (tx_zero),
    .rst_o      (rst_s),
    .bit_valid_o(bitv),
    .bit_o      (bitval)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (rst_s) n_rst = n_rst + 1;
      if (bitv) begin
        n_bit = n_bit + 1;
        last_bit = bitval;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) @(negedge clk);
  endtask

  // Master low pulse of us microseconds, then a settle window.
  task automatic master_pulse(input int us);
    @(negedge clk);
    m_low = 1'b1;
    idle(us * CPU);
    m_low = 1'b0;
    idle(12);
  endtask

  task automatic t_reset_state;
    check(drive_low == 1'b0, "R1 drive", int'(drive_low), 0);
    check(rst_s == 1'b0, "R1 rst", int'(rst_s), 0);
    check(bitv == 1'b0, "R1 bitv", int'(bitv), 0);
  endtask

  task automatic t_reset_presence;
    int r0 = n_rst;
    int b0 = n_bit;
    int width = 0;
    @(negedge clk);
    m_low = 1'b1;
    idle(256 * CPU);
    m_low = 1'b0;
    for (int i = 0; i < (PRES + 10) * CPU; i++) begin
      @(negedge clk);
      if (drive_low) width++;
    end
    idle(20 * CPU);
    check(n_rst - r0 == 1, "R2 reset count at 256us", n_rst - r0, 1);
    check(width == PRES * CPU - 1, "R3 presence width", width, PRES * CPU - 1);
    check(n_bit == b0, "R7 no bit after presence", n_bit - b0, 0);
  endtask

  task automatic t_slot(input int us, input logic exp_bit, input string tag);
    int r0 = n_rst;
    int b0 = n_bit;
    master_pulse(us);
    check(n_bit - b0 == 1, tag, n_bit - b0, 1);
    check(last_bit == exp_bit, tag, int'(last_bit), int'(exp_bit));
    check(n_rst == r0, tag, n_rst - r0, 0);
    idle(5 * CPU);
  endtask

  task automatic t_read_zero;
    int width = 0;
    int b0 = n_bit;
    tx_zero = 1'b1;
    @(negedge clk);
    m_low = 1'b1;
    for (int i = 0; i < (HOLD + 5) * CPU; i++) begin
      @(negedge clk);
      if (i == 2 * CPU) m_low = 1'b0;
      if (drive_low) width++;
    end
    tx_zero = 1'b0;
    idle(5 * CPU);
    check(width == HOLD * CPU - 1, "R6 held zero width", width, HOLD * CPU - 1);
    check(n_bit == b0, "R7 no bit after held zero", n_bit - b0, 0);
  endtask

  task automatic t_read_one;
    int width = 0;
    int b0 = n_bit;
    tx_zero = 1'b0;
    @(negedge clk);
    m_low = 1'b1;
    for (int i = 0; i < (HOLD + 5) * CPU; i++) begin
      @(negedge clk);
      if (i == 2 * CPU) m_low = 1'b0;
      if (drive_low) width++;
    end
    check(width == 0, "R6 no drive without request", width, 0);
    check(n_bit - b0 == 1 && last_bit == 1'b1, "R4 read-one slot bit", int'(last_bit), 1);
    idle(5 * CPU);
  endtask

  task automatic t_idle_request;
    int width = 0;
    int b0 = n_bit;
    tx_zero = 1'b1;
    for (int i = 0; i < 20 * CPU; i++) begin
      @(negedge clk);
      if (drive_low) width++;
    end
    tx_zero = 1'b0;
    check(width == 0, "R9 idle request ignored", width, 0);
    check(n_bit == b0, "R9 no bit on idle line", n_bit - b0, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    idle(3);
    t_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    idle(10);
    t_reset_state();
    t_reset_presence();
    t_slot(15, 1'b1, "R4 15us is one");
    t_slot(1, 1'b1, "R4 1us is one");
    t_slot(16, 1'b0, "R5 16us is zero");
    t_slot(60, 1'b0, "R5 60us is zero");
    t_slot(255, 1'b0, "R2 R5 255us not reset");
    t_read_zero();
    t_read_one();
    t_idle_request();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule